// File: doc/BRIEF.md
# Nibble-Serial Register Command Link

This block carries register writes from a processor core to a pin-side peripheral cell over a four-bit bus. The sending half accepts a request made of a two-bit register select and a 32-bit payload. It turns the request into a short burst of nibbles on the bus and returns the bus to all-zero when the burst ends. The receiving half watches the bus, rebuilds the word and loads it into one of three target registers (mode, X or Y). It only loads the register once the whole word has arrived.

A request whose select is zero is an acknowledge-only command. It has no payload, so it costs two cycles on the bus instead of ten. The receiver answers it with a single-cycle acknowledge pulse. The sender flags busy while it is driving a burst and ignores new requests during that time. It gives a one-cycle done pulse when the burst has finished.

Top module: `niblink_top`

## Requirements
- R1: While reset is active and right after it, `link_nib` is 4'b0000, `busy` and `done` are 0, `ack_pulse` is 0 and the three target registers read zero.
- R2: A request with a nonzero select `s` is accepted on a clock edge where `req_valid` is 1 and `busy` is 0. The following ten cycles then carry, in order: a lead nibble {s, 2'b01}; the eight payload nibbles, bits [3:0] first and bits [31:28] last; and a tail nibble {2'b00, s}.
- R3: A request with select 2'b00 is acknowledge-only. It drives 4'b0001 for one cycle and then 4'b0000 for one cycle, and no payload nibbles are sent.
- R4: `link_nib` is 4'b0000 in every cycle that carries no message nibble. Two messages are always separated by at least one such idle cycle.
- R5: `busy` is 1 in exactly the cycles in which a message nibble is driven. `done` is 1 for exactly one cycle, the cycle right after the last nibble.
- R6: A request presented while `busy` is 1 is dropped. It changes neither the burst in progress nor any target register.
- R7: The register selected by the tail nibble (01 mode, 10 X, 11 Y) takes the complete payload in the cycle after the tail nibble, which is eleven cycles after the accepting edge. The other two registers keep their values, and a partly received word is never visible.
- R8: For an acknowledge-only command, `ack_pulse` is 1 for exactly one cycle, in the cycle after its second nibble. It is 0 at all other times.
- R9: While the bus holds 4'b0000 the receiver stays idle, and none of the target registers or `ack_pulse` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_sel | input | 2 | Register select: 00 acknowledge-only, 01 mode, 10 X, 11 Y |
| req_data | input | 32 | Payload (ignored for acknowledge-only) |
| busy | output | 1 | Sender is driving a message |
| done | output | 1 | One-cycle pulse after a message ends |
| link_nib | output | 4 | The four-bit bus between the two halves |
| reg_mode | output | 32 | Mode register at the pin cell |
| reg_x | output | 32 | X register at the pin cell |
| reg_y | output | 32 | Y register at the pin cell |
| ack_pulse | output | 1 | One-cycle acknowledge-only strobe at the pin cell |

## Verification
The bench holds `req_valid` high across whole bursts, so that it retries on the exact edge where `busy` would first allow a new accept. A sender that dropped `busy` one cycle early would join two messages with no idle nibble between them, and the receiver would then take the second lead nibble as data. Payloads with every nibble different catch nibble order reversed or shifted by one, and all-ones and all-zero payloads catch a data nibble that is confused with the idle code. Acknowledge-only commands sent back to back check that the short frame neither loads a register nor leaves the receiver waiting for payload nibbles.

// File: rtl/niblink_pkg.sv
package niblink_pkg;
  localparam int NIB_W = 4;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_DATA = 2'd1,
    RX_TAIL = 2'd2,
    RX_ACK  = 2'd3
  } rx_state_t;

  // First nibble of a message: select in the top bits, marker in bit 0.
  function automatic logic [NIB_W-1:0] lead_nib(input logic [1:0] sel);
    return {sel, 2'b01};
  endfunction

  // Last nibble of a full write: select in the low bits.
  function automatic logic [NIB_W-1:0] tail_nib(input logic [1:0] sel);
    return {2'b00, sel};
  endfunction

  // Number of nibbles in a message.
  function automatic int unsigned frame_len(input logic [1:0] sel, input int unsigned nibbles);
    return (sel == 2'b00) ? 2 : nibbles + 2;
  endfunction
endpackage

// File: rtl/niblink_tx.sv
module niblink_tx
  import niblink_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_sel,
  input  logic [DATA_W-1:0] req_data,
  output logic [NIB_W-1:0]  link_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int NIBBLES = DATA_W / NIB_W;
  localparam int SW      = $clog2(NIBBLES + 3);

  logic [SW-1:0]     slot_q;
  logic [DATA_W-1:0] sh_q;
  logic [1:0]        sel_q;
  logic [NIB_W-1:0]  link_q;
  logic              busy_q;
  logic              done_q;

  logic              accept;
  logic              at_end;
  logic [SW-1:0]     last_slot;

  assign accept    = req_valid && !busy_q;
  assign last_slot = SW'(frame_len(sel_q, NIBBLES));
  assign at_end    = busy_q && (slot_q == last_slot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      sh_q   <= '0;
      sel_q  <= 2'b00;
      link_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        link_q <= lead_nib(req_sel);
        sh_q   <= req_data;
        sel_q  <= req_sel;
        slot_q <= SW'(1);
        busy_q <= 1'b1;
      end else if (at_end) begin
        link_q <= '0;
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else if (busy_q) begin
        slot_q <= slot_q + SW'(1);
        if (sel_q == 2'b00) begin
          link_q <= '0;
        end else if (slot_q <= SW'(NIBBLES)) begin
          link_q <= sh_q[NIB_W-1:0];
          sh_q   <= sh_q >> NIB_W;
        end else begin
          link_q <= tail_nib(sel_q);
        end
      end
    end
  end

  assign link_o = link_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  assert_start_marker_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> link_q[0]);
  assert_ignore_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !at_end) |=> (busy_q && $stable(sel_q)));
  assert_idle_after_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (link_q == '0 && done_q));
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/niblink_rx.sv
module niblink_rx
  import niblink_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  link_i,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] x_o,
  output logic [DATA_W-1:0] y_o,
  output logic              ack_o
);
  localparam int NIBBLES = DATA_W / NIB_W;
  localparam int CW      = $clog2(NIBBLES);

  rx_state_t         st_q;
  logic [CW-1:0]     cnt_q;
  logic [1:0]        sel_q;
  logic [DATA_W-1:0] shadow_q;
  logic [DATA_W-1:0] mode_q, x_q, y_q;
  logic              ack_q;

  logic commit;
  logic ack_fire;

  assign commit   = (st_q == RX_TAIL) && (link_i == tail_nib(sel_q));
  assign ack_fire = (st_q == RX_ACK) && (link_i == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= RX_IDLE;
      cnt_q    <= '0;
      sel_q    <= 2'b00;
      shadow_q <= '0;
      mode_q   <= '0;
      x_q      <= '0;
      y_q      <= '0;
      ack_q    <= 1'b0;
    end else begin
      ack_q <= ack_fire;
      case (st_q)
        RX_IDLE: begin
          if (link_i != '0) begin
            sel_q <= link_i[3:2];
            cnt_q <= '0;
            st_q  <= (link_i[3:2] == 2'b00) ? RX_ACK : RX_DATA;
          end
        end
        RX_DATA: begin
          shadow_q <= {link_i, shadow_q[DATA_W-1:NIB_W]};
          cnt_q    <= cnt_q + CW'(1);
          if (cnt_q == CW'(NIBBLES - 1)) st_q <= RX_TAIL;
        end
        RX_TAIL: begin
          if (commit) begin
            case (sel_q)
              2'b01:   mode_q <= shadow_q;
              2'b10:   x_q    <= shadow_q;
              default: y_q    <= shadow_q;
            endcase
          end
          st_q <= RX_IDLE;
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  assign mode_o = mode_q;
  assign x_o    = x_q;
  assign y_o    = y_q;
  assign ack_o  = ack_q;

  assert_no_partial_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(mode_q) && $stable(x_q) && $stable(y_q)));
  assert_ack_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);
  assert_idle_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_IDLE && link_i == '0) |=> (st_q == RX_IDLE && !ack_q));
endmodule

// File: rtl/niblink_top.sv
module niblink_top
  import niblink_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_sel,
  input  logic [DATA_W-1:0] req_data,
  output logic              busy,
  output logic              done,
  output logic [3:0]        link_nib,
  output logic [DATA_W-1:0] reg_mode,
  output logic [DATA_W-1:0] reg_x,
  output logic [DATA_W-1:0] reg_y,
  output logic              ack_pulse
);
  logic [NIB_W-1:0] link_w;

  niblink_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
    .req_data(req_data), .link_o(link_w), .busy_o(busy), .done_o(done)
  );

  niblink_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .link_i(link_w), .mode_o(reg_mode),
    .x_o(reg_x), .y_o(reg_y), .ack_o(ack_pulse)
  );

  assign link_nib = link_w;
endmodule

// File: tb/sim_niblink_top.sv
`timescale 1ns/1ps
module sim_niblink_top;
  localparam int DATA_W = 32;
  localparam int NIB    = DATA_W / 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [1:0]        req_sel = 2'b00;
  logic [DATA_W-1:0] req_data = '0;
  logic              busy, done, ack_pulse;
  logic [3:0]        link_nib;
  logic [DATA_W-1:0] reg_mode, reg_x, reg_y;

  niblink_top #(.DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
    .req_data(req_data), .busy(busy), .done(done), .link_nib(link_nib),
    .reg_mode(reg_mode), .reg_x(reg_x), .reg_y(reg_y), .ack_pulse(ack_pulse)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got=%h exp=%h at %0t", tag, what, got, exp, $time);
    end
  endtask

  // Behavioural reference model
  int          q[$];
  bit          m_busy, m_done, m_ack, m_short;
  logic [3:0]  m_link;
  logic [31:0] m_mode, m_x, m_y, pend_data;
  logic [1:0]  pend_sel;
  int          pend_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_busy = 0; m_done = 0; m_ack = 0; m_short = 0; m_link = 4'h0;
      m_mode = '0; m_x = '0; m_y = '0; pend_cnt = 0; pend_sel = 2'b00; pend_data = '0;
    end else begin
      m_ack = 0;
      m_done = 0;
      if (pend_cnt > 0) begin
        pend_cnt--;
        if (pend_cnt == 0) begin
          case (pend_sel)
            2'b00: m_ack = 1;
            2'b01: m_mode = pend_data;
            2'b10: m_x = pend_data;
            default: m_y = pend_data;
          endcase
        end
      end
      if (req_valid && !m_busy) begin
        q.delete();
        q.push_back({req_sel, 2'b01});
        if (req_sel != 2'b00) begin
          for (int i = 0; i < NIB; i++) q.push_back(int'((req_data >> (4 * i)) & 32'hF));
          q.push_back({2'b00, req_sel});
          pend_cnt = NIB + 2;
        end else begin
          q.push_back(0);
          pend_cnt = 2;
        end
        pend_sel  = req_sel;
        pend_data = req_data;
        m_short   = (req_sel == 2'b00);
        m_link    = 4'(q.pop_front());
        m_busy    = 1;
      end else if (q.size() > 0) begin
        m_link = 4'(q.pop_front());
      end else begin
        if (m_busy) m_done = 1;
        m_busy = 0;
        m_link = 4'h0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(!m_busy ? "R4" : (m_short ? "R3" : "R2"), "link_nib", 32'(link_nib), 32'(m_link));
      chk("R5", "busy", 32'(busy), 32'(m_busy));
      chk("R5", "done", 32'(done), 32'(m_done));
      chk("R7", "reg_mode", reg_mode, m_mode);
      chk("R7", "reg_x", reg_x, m_x);
      chk("R7", "reg_y", reg_y, m_y);
      chk("R8", "ack_pulse", 32'(ack_pulse), 32'(m_ack));
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_sel = s; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    idle(12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "link_nib", 32'(link_nib), 32'h0);
    chk("R1", "busy", 32'(busy), 32'h0);
    chk("R1", "done", 32'(done), 32'h0);
    chk("R1", "ack_pulse", 32'(ack_pulse), 32'h0);
    chk("R1", "regs", reg_mode | reg_x | reg_y, 32'h0);
    rst_n = 1'b1;
    idle(2);

    send(2'b01, 32'h1234_5678);   // R2 distinct nibbles into mode
    send(2'b10, 32'hFFFF_FFFF);   // R2 all ones into X
    send(2'b11, 32'hA5C3_0F96);   // R2 mixed into Y
    send(2'b11, 32'h0000_0000);   // R2 all zero payload
    send(2'b00, 32'hDEAD_BEEF);   // R3 acknowledge-only

    // R6: request changes while busy; only the first must take effect
    @(negedge clk);
    req_valid = 1'b1; req_sel = 2'b10; req_data = 32'h1111_1111;
    @(negedge clk);
    req_sel = 2'b11; req_data = 32'h2222_2222;
    idle(5);
    req_valid = 1'b0;
    idle(10);
    chk("R6", "reg_x after busy request", reg_x, 32'h1111_1111);
    chk("R6", "reg_y untouched", reg_y, 32'h0000_0000);

    // R4: held request retries at the first legal edge
    @(negedge clk);
    req_valid = 1'b1; req_sel = 2'b01; req_data = 32'hCAFE_0001;
    idle(30);
    req_sel = 2'b00;
    idle(10);
    req_valid = 1'b0;
    idle(14);

    // R9: long idle stretch, nothing moves
    idle(40);
    chk("R9", "reg_mode stable", reg_mode, 32'hCAFE_0001);
    chk("R9", "reg_x stable", reg_x, 32'h1111_1111);
    chk("R9", "ack quiet", 32'(ack_pulse), 32'h0);
    chk("R9", "link quiet", 32'(link_nib), 32'h0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R5 watchdog got=hung exp=finished");
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule